// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block sits between a host register port and a downstream request/response port. It gives the host an indirect way to reach devices behind a bridge. Software first loads a 32-bit target address register. It then reads or writes one of two data registers. An access to the configuration data register starts one configuration cycle downstream, and an access to the port data register starts one I/O-port cycle. The host port is held until the downstream side answers. Byte and halfword accesses to a data register are steered onto the correct byte lanes by the low offset bits. Read data comes back right-justified.

The block also holds a 32-bit window-enable bitmap. Each bit of the bitmap claims one fixed 8 MB slice of the top 256 MB of host memory space. A separate combinational lookup tells the fabric whether a given host address falls in a claimed slice. The lookup takes only address bits 31:23, the only bits that take part in it.

Top module: `cfgwin_bridge`

## Requirements
- R1: After reset the target address register and the window bitmap both read as zero, no downstream request is active, and no address is claimed.
- R2: A write to offset 0x064 loads the 32-bit target address register. A read of 0x064 returns the last value written.
- R3: Offset 0x060 holds the window bitmap and reads back its last write. The claim flag is 1 exactly when address bits 31:28 equal 0xF and bitmap bit [addr 27:23] is set, so a bitmap of zero claims nothing. A new bitmap affects the claim flag from the cycle after the write completes.
- R4: An access to 0x068..0x06B starts a configuration cycle (kind 0). Its address is the target register with bits 1:0 forced to zero, which keeps bus in 23:16, device/function in 15:8 and a dword-aligned register number in 7:0.
- R5: An access to 0x06C..0x06F starts an I/O-port cycle (kind 1). Its address is {16'h0, target[15:2], 2'b00}.
- R6: The host size code is 0 for byte, 1 for halfword and 2 for word. The byte enables are 1<<off[1:0] for a byte. For a halfword they are 4'b0011 when off[1]=0 and 4'b1100 when off[1]=1. For a word they are 4'b1111 whatever the low bits are.
- R7: The downstream write flag copies the host write flag. The write data is the host write word shifted left by 8 times the aligned lane, and it is zero for reads.
- R8: A data access raises dn_req on the clock after it is accepted. dn_req, together with the address, enables and data it carries, stays unchanged until dn_rsp. host_ready rises in the same cycle as dn_rsp, and dn_req is low in the next cycle. Each access makes exactly one downstream cycle.
- R9: Read data returned to the host is dn_rdata shifted right by 8 times the aligned lane, with the bytes beyond the access size cleared.
- R10: An access to any offset other than a data register completes in the cycle in which it is presented. An unmapped offset reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 12 | Register byte offset |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word |
| host_wdata | input | 32 | Write data, right-justified |
| host_ready | output | 1 | Access completes this cycle |
| host_rdata | output | 32 | Read data, valid with host_ready |
| dn_req | output | 1 | Downstream cycle pending |
| dn_kind | output | 1 | 0 configuration, 1 I/O port |
| dn_we | output | 1 | Downstream write flag |
| dn_addr | output | 32 | Downstream cycle address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data, lane-placed |
| dn_rsp | input | 1 | Downstream cycle finished |
| dn_rdata | input | 32 | Downstream read data, valid with dn_rsp |
| mem_hi | input | 9 | Host memory address bits 31:23 to test |
| mem_claim | output | 1 | Address lies in an enabled window |

## Verification
Two pairs of functions can meet in the same cycle. A window-bitmap write can complete while the claim lookup is probing a slice that the write flips. The bench steps mem_hi on every clock and keeps its own bitmap copy, which it updates at the completing edge. The old value must therefore hold in the write cycle and the new value from the next cycle on. A downstream response can also arrive in the very first cycle dn_req is high. Latencies from zero to three cycles are mixed across all size and lane combinations, and the number of stalled cycles seen by the host must equal the latency plus one.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

   typedef enum logic [0:0] {
      CYC_CFG = 1'b0,
      CYC_IO  = 1'b1
   } cyc_kind_e;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } win_state_e;

endpackage

// File: rtl/cfgwin_lane.sv
module cfgwin_lane #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LSB_W = $clog2(LANES),
   localparam int SZ_W  = $clog2(LSB_W + 1)
) (
   input  logic [SZ_W-1:0]   size,
   input  logic [LSB_W-1:0]  lane,
   input  logic [DATA_W-1:0] wr_in,
   input  logic [DATA_W-1:0] rd_in,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wr_out,
   output logic [DATA_W-1:0] rd_out
);

   logic [SZ_W-1:0]   eff;
   logic [LSB_W-1:0]  base;
   logic [DATA_W-1:0] rd_shift;

   always_comb begin
      eff  = (size > SZ_W'(LSB_W)) ? SZ_W'(LSB_W) : size;
      base = (lane >> eff) << eff;
   end

   assign wr_out   = wr_in << {base, 3'b000};
   assign rd_shift = rd_in >> {base, 3'b000};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i] = ((LSB_W'(i) >> eff) == (lane >> eff));
      assign rd_out[8*i +: 8] = (i < (32'd1 << eff)) ? rd_shift[8*i +: 8] : 8'h00;
   end

   // R6: the enables span exactly the access width
   always_comb begin
      assert_be_span_R6: assert ($countones(be) == (32'd1 << eff));
   end

endmodule

// File: rtl/cfgwin_winmap.sv
module cfgwin_winmap #(
   parameter int WIN_BITS   = 32,
   parameter int PREFIX_W   = 4,
   parameter int MEM_PREFIX = 15,
   localparam int IDX_W     = $clog2(WIN_BITS),
   localparam int HI_W      = PREFIX_W + IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WIN_BITS-1:0] wr_data,
   input  logic [HI_W-1:0]     probe_hi,
   output logic [WIN_BITS-1:0] win_q,
   output logic                claim
);

   if ((1 << IDX_W) != WIN_BITS) begin : g_bad_bits
      $error("WIN_BITS must be a power of two");
   end
   if (PREFIX_W < 1) begin : g_bad_prefix
      $error("window prefix must be at least one bit");
   end

   logic [PREFIX_W-1:0] prefix;
   logic [IDX_W-1:0]    slice;

   assign prefix = probe_hi[HI_W-1 -: PREFIX_W];
   assign slice  = probe_hi[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     win_q <= '0;
      else if (wr_en) win_q <= wr_data;
   end

   assign claim = (prefix == PREFIX_W'(MEM_PREFIX)) && win_q[slice];

   assert_win_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(win_q));

   assert_zero_no_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_q == '0) |-> !claim);

endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
   import cfgwin_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic host_req,
   input  logic is_data,
   input  logic dn_rsp,
   output logic launch,
   output logic busy,
   output logic rsp_done,
   output logic reg_done
);

   win_state_e state_q, state_d;

   assign busy     = (state_q == ST_BUSY);
   assign launch   = !busy && host_req && is_data;
   assign reg_done = !busy && host_req && !is_data;
   assign rsp_done = busy && dn_rsp;

   always_comb begin
      state_d = state_q;
      if (launch)   state_d = ST_BUSY;
      if (rsp_done) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dn_rsp) |=> busy);

endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge
   import cfgwin_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int OFF_W      = 12,
   parameter int PORT_W     = 16,
   parameter int WIN_BITS   = 32,
   parameter int WIN_SHIFT  = 23,
   parameter int MEM_PREFIX = 15,
   parameter logic [OFF_W-1:0] OFF_WIN   = 'h060,
   parameter logic [OFF_W-1:0] OFF_TADDR = 'h064,
   parameter logic [OFF_W-1:0] OFF_CFG   = 'h068,
   parameter logic [OFF_W-1:0] OFF_IO    = 'h06C,
   localparam int LANES    = DATA_W / 8,
   localparam int LSB_W    = $clog2(LANES),
   localparam int SZ_W     = $clog2(LSB_W + 1),
   localparam int IDX_W    = $clog2(WIN_BITS),
   localparam int HI_W     = DATA_W - WIN_SHIFT,
   localparam int PREFIX_W = HI_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [OFF_W-1:0]  host_off,
   input  logic [SZ_W-1:0]   host_size,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              dn_req,
   output logic              dn_kind,
   output logic              dn_we,
   output logic [DATA_W-1:0] dn_addr,
   output logic [LANES-1:0]  dn_be,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_rsp,
   input  logic [DATA_W-1:0] dn_rdata,
   input  logic [HI_W-1:0]   mem_hi,
   output logic              mem_claim
);

   if (DATA_W % 8 != 0 || LANES < 2) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (WIN_BITS > DATA_W) begin : g_bad_win
      $error("window bitmap must fit in one data word");
   end
   if (PORT_W > DATA_W || PORT_W <= LSB_W) begin : g_bad_port
      $error("PORT_W out of range");
   end

   // ---- offset decode ----
   logic [OFF_W-LSB_W-1:0] word;
   logic sel_win, sel_taddr, sel_cfg, sel_io, is_data;

   assign word      = host_off[OFF_W-1:LSB_W];
   assign sel_win   = (word == OFF_WIN[OFF_W-1:LSB_W]);
   assign sel_taddr = (word == OFF_TADDR[OFF_W-1:LSB_W]);
   assign sel_cfg   = (word == OFF_CFG[OFF_W-1:LSB_W]);
   assign sel_io    = (word == OFF_IO[OFF_W-1:LSB_W]);
   assign is_data   = sel_cfg || sel_io;

   // ---- sequencing ----
   logic launch, busy, rsp_done, reg_done;

   cfgwin_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_req (host_req),
      .is_data  (is_data),
      .dn_rsp   (dn_rsp),
      .launch   (launch),
      .busy     (busy),
      .rsp_done (rsp_done),
      .reg_done (reg_done)
   );

   // ---- target address register ----
   logic [DATA_W-1:0] taddr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             taddr_q <= '0;
      else if (reg_done && host_we && sel_taddr) taddr_q <= host_wdata;
   end

   // ---- window bitmap and claim lookup ----
   logic [WIN_BITS-1:0] win_q;

   cfgwin_winmap #(
      .WIN_BITS   (WIN_BITS),
      .PREFIX_W   (PREFIX_W),
      .MEM_PREFIX (MEM_PREFIX)
   ) u_winmap (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_done && host_we && sel_win),
      .wr_data  (host_wdata[WIN_BITS-1:0]),
      .probe_hi (mem_hi),
      .win_q    (win_q),
      .claim    (mem_claim)
   );

   // ---- lane steering, shared by launch and response ----
   logic [SZ_W-1:0]   size_q;
   logic [LSB_W-1:0]  lane_q;
   logic [LANES-1:0]  lane_be;
   logic [DATA_W-1:0] lane_wr, lane_rd;

   cfgwin_lane #(.DATA_W(DATA_W)) u_lane (
      .size   (busy ? size_q : host_size),
      .lane   (busy ? lane_q : host_off[LSB_W-1:0]),
      .wr_in  (host_wdata),
      .rd_in  (dn_rdata),
      .be     (lane_be),
      .wr_out (lane_wr),
      .rd_out (lane_rd)
   );

   // ---- downstream command capture ----
   cyc_kind_e         kind_q;
   logic              we_q;
   logic [DATA_W-1:0] addr_q, wdata_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] cfg_addr, io_addr;

   assign cfg_addr = {taddr_q[DATA_W-1:LSB_W], {LSB_W{1'b0}}};
   assign io_addr  = {{(DATA_W-PORT_W){1'b0}}, taddr_q[PORT_W-1:LSB_W], {LSB_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= CYC_CFG;
         we_q    <= 1'b0;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         lane_q  <= '0;
         size_q  <= '0;
      end else if (launch) begin
         kind_q  <= sel_io ? CYC_IO : CYC_CFG;
         we_q    <= host_we;
         addr_q  <= sel_io ? io_addr : cfg_addr;
         be_q    <= lane_be;
         wdata_q <= host_we ? lane_wr : '0;
         lane_q  <= host_off[LSB_W-1:0];
         size_q  <= host_size;
      end
   end

   assign dn_req   = busy;
   assign dn_kind  = kind_q;
   assign dn_we    = we_q;
   assign dn_addr  = addr_q;
   assign dn_be    = be_q;
   assign dn_wdata = wdata_q;

   // ---- host return path ----
   assign host_ready = reg_done || rsp_done;

   always_comb begin
      host_rdata = '0;
      if (rsp_done) begin
         host_rdata = lane_rd;
      end else if (reg_done && !host_we) begin
         if (sel_taddr)    host_rdata = taddr_q;
         else if (sel_win) host_rdata = DATA_W'(win_q);
      end
   end

   assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && !dn_rsp) |=> (dn_req && $stable(dn_addr) && $stable(dn_be)
                               && $stable(dn_wdata) && $stable(dn_kind)));

   assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && dn_rsp) |=> !dn_req);

   assert_reg_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !dn_req && !is_data) |-> host_ready);

endmodule

// File: tb/cfgwin_bridge_tb_top.sv
module cfgwin_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [11:0] host_off = '0;
   logic [1:0]  host_size = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ready;
   logic [31:0] host_rdata;
   logic        dn_req, dn_kind, dn_we;
   logic [31:0] dn_addr, dn_wdata;
   logic [3:0]  dn_be;
   logic        dn_rsp = 1'b0;
   logic [31:0] dn_rdata = '0;
   logic [8:0]  mem_hi = '0;
   logic        mem_claim;

   always #10 clk = ~clk;

   cfgwin_bridge dut_i (.*);

   int total = 0, bad = 0, cyc = 0;
   bit run = 0, finished = 0;
   logic [31:0] m_taddr = '0, m_win = '0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---- downstream responder ----
   int rsp_lat = 0, rsp_cnt = 0, dn_starts = 0;
   logic [31:0] rsp_val = '0;
   logic [31:0] cap_addr, cap_wdata;
   logic [3:0]  cap_be;
   logic        cap_kind, cap_we;
   bit moved = 0, prev_req = 0;

   always @(negedge clk) begin
      #1;
      if (dn_req) begin
         if (!prev_req) begin
            dn_starts++;
            cap_addr = dn_addr; cap_wdata = dn_wdata; cap_be = dn_be;
            cap_kind = dn_kind; cap_we = dn_we;
            rsp_cnt = 0; moved = 0;
         end else if (cap_addr != dn_addr || cap_be != dn_be || cap_wdata != dn_wdata
                      || cap_kind != dn_kind || cap_we != dn_we) begin
            moved = 1;
         end
         if (rsp_cnt == rsp_lat) begin
            dn_rsp = 1'b1;
            dn_rdata = rsp_val;
         end else begin
            dn_rsp = 1'b0;
         end
         rsp_cnt++;
      end else begin
         dn_rsp = 1'b0;
      end
      prev_req = dn_req;
   end

   // ---- per-clock claim model (R3, R1) ----
   always @(negedge clk) begin
      mem_hi = {((cyc % 3) == 0) ? 4'h7 : 4'hF, 5'(cyc * 7)};
      #4;
      if (run) begin
         logic exp_c;
         exp_c = (mem_hi[8:5] == 4'hF) && m_win[mem_hi[4:0]];
         check(mem_claim == exp_c, "R3 claim", 32'(mem_claim), 32'(exp_c));
      end
   end

   // ---- watchdog ----
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic acc(input bit we, input logic [11:0] off, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output int waits);
      @(negedge clk);
      host_req = 1; host_we = we; host_off = off; host_size = sz; host_wdata = wd;
      waits = 0;
      #3;
      while (!host_ready && waits < 50) begin
         waits++;
         @(negedge clk); #3;
      end
      rd = host_rdata;
      @(posedge clk); #1;
      host_req = 0; host_we = 0;
      if (we && off[11:2] == 10'h019) m_taddr = wd;
      if (we && off[11:2] == 10'h018) m_win = wd;
   endtask

   task automatic reg_read(input logic [11:0] off, input logic [31:0] exp, input string req);
      logic [31:0] rd; int w;
      acc(0, off, 2'd2, 32'h0, rd, w);
      check(rd == exp, req, rd, exp);
      check(w == 0, "R10 register access wait", 32'(w), 32'd0);
   endtask

   task automatic reg_write(input logic [11:0] off, input logic [31:0] val);
      logic [31:0] rd; int w;
      acc(1, off, 2'd2, val, rd, w);
   endtask

   task automatic dacc(input bit we, input logic [11:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input int lat, input logic [31:0] val);
      logic [31:0] rd, exp_addr, exp_wd, exp_rd;
      logic [3:0]  exp_be;
      logic [63:0] mask;
      int w, s0, eff, base, nb;
      bit io;
      rsp_lat = lat; rsp_val = val; s0 = dn_starts;
      acc(we, off, sz, wd, rd, w);
      io   = (off[11:2] == 10'h01B);
      eff  = (sz > 2) ? 2 : int'(sz);
      base = (int'(off[1:0]) >> eff) << eff;
      nb   = 1 << eff;
      exp_be   = 4'(((1 << nb) - 1) << base);
      exp_wd   = we ? (wd << (8 * base)) : 32'h0;
      mask     = (64'd1 << (8 * nb)) - 64'd1;
      exp_rd   = 32'((64'(val) >> (8 * base)) & mask);
      exp_addr = io ? {16'h0, m_taddr[15:2], 2'b00} : {m_taddr[31:2], 2'b00};
      if (io) begin
         check(cap_kind == 1'b1, "R5 kind", 32'(cap_kind), 32'd1);
         check(cap_addr == exp_addr, "R5 port address", cap_addr, exp_addr);
      end else begin
         check(cap_kind == 1'b0, "R4 kind", 32'(cap_kind), 32'd0);
         check(cap_addr == exp_addr, "R4 config address", cap_addr, exp_addr);
      end
      check(cap_be == exp_be, "R6 byte enables", 32'(cap_be), 32'(exp_be));
      check(cap_we == we, "R7 write flag", 32'(cap_we), 32'(we));
      check(cap_wdata == exp_wd, "R7 write data", cap_wdata, exp_wd);
      check(w == lat + 1, "R8 stall length", 32'(w), 32'(lat + 1));
      check(dn_starts - s0 == 1, "R8 one downstream cycle", 32'(dn_starts - s0), 32'd1);
      check(!moved, "R8 fields held", 32'(moved), 32'd0);
      if (!we) check(rd == exp_rd, "R9 read data", rd, exp_rd);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      run = 1;
      @(negedge clk); #5;
      check(dn_req == 1'b0, "R1 no request after reset", 32'(dn_req), 32'd0);
      reg_read(12'h064, 32'h0, "R1 target register reset");
      reg_read(12'h060, 32'h0, "R1 window reset");

      // R2 target register readback
      reg_write(12'h064, 32'hDEAD_BEEF);
      reg_read(12'h064, 32'hDEAD_BEEF, "R2 readback");
      reg_write(12'h064, 32'h1234_5677);
      reg_read(12'h064, 32'h1234_5677, "R2 readback second");

      // R3 window bitmap, claim compared every clock
      reg_write(12'h060, 32'h0000_0005);
      reg_read(12'h060, 32'h0000_0005, "R3 window readback");
      repeat (40) @(negedge clk);
      reg_write(12'h060, 32'h8000_0001);
      repeat (40) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         reg_write(12'h060, 32'h1 << (k * 4 + 1));
         @(negedge clk);
      end
      reg_write(12'h060, 32'h0);
      repeat (40) @(negedge clk);
      reg_write(12'h060, 32'hA5A5_3C3C);

      // R4 configuration cycles: bus 03, devfn 41, register 3D
      reg_write(12'h064, 32'h0003_413D);
      for (int sz = 0; sz < 3; sz++)
         for (int ln = 0; ln < 4; ln++) begin
            dacc(1, 12'h068 + 12'(ln), 2'(sz), 32'hC1C2_C3C4 + 32'(ln), (sz + ln) % 4, 32'h0);
            dacc(0, 12'h068 + 12'(ln), 2'(sz), 32'h0, (sz + ln + 1) % 4, 32'h8877_6655 ^ 32'(ln * 3));
         end

      // R5 I/O-port cycles
      reg_write(12'h064, 32'hABCD_1235);
      for (int sz = 0; sz < 3; sz++)
         for (int ln = 0; ln < 4; ln++) begin
            dacc(1, 12'h06C + 12'(ln), 2'(sz), 32'h0102_0304 << ln, ln % 4, 32'h0);
            dacc(0, 12'h06C + 12'(ln), 2'(sz), 32'h0, (3 - ln), 32'hF0E1_D2C3 + 32'(sz));
         end

      // R10 unmapped offset ignored
      reg_write(12'h074, 32'h5555_AAAA);
      reg_read(12'h074, 32'h0, "R10 unmapped reads zero");
      reg_read(12'h064, 32'hABCD_1235, "R10 target register untouched");
      reg_read(12'h060, 32'hA5A5_3C3C, "R10 window untouched");

      repeat (5) @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule